// File: doc/BRIEF.md
# Prefix Carry Lookahead Adder

This block adds two N-bit operands and a carry-in. It returns every internal carry as well as the sum. Each operand bit pair is reduced to a two-bit status symbol. The symbol says whether the bit pair generates a carry, passes the incoming carry through unchanged (propagate), or kills it (annihilate). The carry-in is placed below the least significant bit as an extra, already-resolved symbol.

A Kogge-Stone prefix tree then folds the symbols from the least significant end upward in logarithmic depth. Every prefix position ends up fully resolved, either to generate (carry 1) or to annihilate (carry 0). The sum bits are the propagate flag of each position XOR the carry entering it.

The datapath is combinational. A parameter can add one output register stage, which has a synchronous active-high reset. The block is meant to be instantiated wherever a wide adder needs every carry, for example to feed flag logic or a wider segmented datapath.

Top module: `pfx_carry_adder`

## Requirements
- R1: Each bit position k is classified on two bits (G,P) as generate = 2'b10 when a_in[k] and b_in[k] are both 1, annihilate = 2'b00 when both are 0, and propagate = 2'b01 when exactly one is 1. The code 2'b11 never appears.
- R2: A propagate position passes the carry arriving from below to the next position unchanged, so carry_out[k+1] equals carry_out[k] whenever exactly one of a_in[k], b_in[k] is 1.
- R3: An annihilate position forces carry_out[k+1] to 0, and a generate position forces it to 1, whatever the less significant bits and the carry-in are.
- R4: The carry-in enters as the symbol below bit 0 (generate when cin is 1, annihilate when it is 0), so carry_out[0] always equals cin.
- R5: carry_out[k] for k in 0..N equals bit k of the sum of the low k bits of a_in, the low k bits of b_in, and cin.
- R6: sum_out equals (a_in + b_in + cin) modulo 2^N, and carry_out[N] is the carry out of that N-bit addition.
- R7: With REG_OUT = 0 the outputs follow the inputs in the same cycle. With REG_OUT = 1 they show the inputs sampled at the previous rising clock edge.
- R8: With REG_OUT = 1, a clock edge with rst high sets sum_out and carry_out to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | WIDTH | First operand |
| b_in | input | WIDTH | Second operand |
| cin | input | 1 | Carry into bit 0 |
| sum_out | output | WIDTH | Sum bits |
| carry_out | output | WIDTH+1 | Carry into each position; bit 0 is cin, bit WIDTH is carry-out |

## Verification
The embedded properties check these on every cycle: the carry-in appears at position zero, each carry agrees with the bit-local generate/propagate relation to the carry below it, no resolved prefix symbol stays at propagate, no illegal symbol code occurs, and the registered outputs match the previous cycle's full addition. Some behaviour is shown only by the bench's scenarios:
- the exact cycle in which a registered result becomes visible, since the old value must persist until the edge;
- the reset clearing of the outputs;
- that a single generate or annihilate position overrides a long propagate run below it.

Exhaustive 8-bit operands and random 32-bit operands, each with both carry-in values, compare the sum and every carry against arithmetic done in the bench.

// File: rtl/pfx_pkg.sv
`timescale 1ns/1ps
package pfx_pkg;

    // Two-bit carry status symbol, encoded as {G,P}
    typedef enum logic [1:0] {
        SYM_ANNIH = 2'b00,
        SYM_PROP  = 2'b01,
        SYM_GEN   = 2'b10
    } csym_e;

    // Fold a more significant symbol over a less significant one
    function automatic csym_e sym_combine(csym_e hi, csym_e lo);
        return (hi == SYM_PROP) ? lo : hi;
    endfunction

    // Classify one operand bit pair
    function automatic csym_e sym_of_bits(logic x, logic y);
        if (x & y)
            return SYM_GEN;
        else if (x | y)
            return SYM_PROP;
        else
            return SYM_ANNIH;
    endfunction

    // The carry-in is always an already-resolved symbol
    function automatic csym_e sym_of_carry(logic c);
        return c ? SYM_GEN : SYM_ANNIH;
    endfunction

    // Number of Kogge-Stone levels needed to span n elements
    function automatic int unsigned tree_levels(int unsigned n);
        return (n < 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/pfx_classify.sv
`timescale 1ns/1ps
module pfx_classify
    import pfx_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output csym_e            bit_sym_o [WIDTH],
    output csym_e            cin_sym_o
);

    assign cin_sym_o = sym_of_carry(cin_i);

    for (genvar k = 0; k < WIDTH; k++) begin : g_bit
        assign bit_sym_o[k] = sym_of_bits(a_i[k], b_i[k]);

        // R1: the unused {G,P} = 11 code must never be produced
        always_comb begin
            p_code_legal_r1: assert ($onehot0(bit_sym_o[k]));
        end
    end

endmodule

// File: rtl/pfx_prefix_tree.sv
`timescale 1ns/1ps
module pfx_prefix_tree
    import pfx_pkg::*;
#(
    parameter int unsigned COUNT = 33
) (
    input  csym_e seq_i [COUNT],
    output csym_e res_o [COUNT]
);

    localparam int unsigned LEVELS = tree_levels(COUNT);

    csym_e stage [LEVELS+1][COUNT];

    for (genvar j = 0; j < COUNT; j++) begin : g_in
        assign stage[0][j] = seq_i[j];
        assign res_o[j]    = stage[LEVELS][j];
    end

    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
        localparam int unsigned SPAN = 1 << l;
        for (genvar j = 0; j < COUNT; j++) begin : g_node
            if (j >= SPAN) begin : g_op
                assign stage[l+1][j] = sym_combine(stage[l][j], stage[l][j-SPAN]);
            end else begin : g_wire
                assign stage[l+1][j] = stage[l][j];
            end
        end
    end

endmodule

// File: rtl/pfx_sum_stage.sv
`timescale 1ns/1ps
module pfx_sum_stage
    import pfx_pkg::*;
#(
    parameter int unsigned WIDTH = 32
) (
    input  csym_e            bit_sym_i [WIDTH],
    input  csym_e            res_i     [WIDTH+1],
    output logic [WIDTH:0]   carry_o,
    output logic [WIDTH-1:0] sum_o
);

    for (genvar j = 0; j <= WIDTH; j++) begin : g_car
        assign carry_o[j] = (res_i[j] == SYM_GEN);
    end

    for (genvar k = 0; k < WIDTH; k++) begin : g_sum
        assign sum_o[k] = (bit_sym_i[k] == SYM_PROP) ^ carry_o[k];
    end

endmodule

// File: rtl/pfx_carry_adder.sv
`timescale 1ns/1ps
module pfx_carry_adder
    import pfx_pkg::*;
#(
    parameter int unsigned WIDTH   = 32,
    parameter bit          REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] a_in,
    input  logic [WIDTH-1:0] b_in,
    input  logic             cin,
    output logic [WIDTH-1:0] sum_out,
    output logic [WIDTH:0]   carry_out
);

    localparam int unsigned COUNT = WIDTH + 1;

    csym_e            bit_sym [WIDTH];
    csym_e            cin_sym;
    csym_e            seq     [COUNT];
    csym_e            res     [COUNT];
    logic [WIDTH:0]   carry_c;
    logic [WIDTH-1:0] sum_c;
    logic [WIDTH:0]   ref_total;

    pfx_classify #(.WIDTH(WIDTH)) u_class (
        .a_i       (a_in),
        .b_i       (b_in),
        .cin_i     (cin),
        .bit_sym_o (bit_sym),
        .cin_sym_o (cin_sym)
    );

    // Position 0 of the prefix holds the carry-in, position k+1 holds bit k
    assign seq[0] = cin_sym;
    for (genvar k = 0; k < WIDTH; k++) begin : g_seq
        assign seq[k+1] = bit_sym[k];
    end

    pfx_prefix_tree #(.COUNT(COUNT)) u_tree (
        .seq_i (seq),
        .res_o (res)
    );

    pfx_sum_stage #(.WIDTH(WIDTH)) u_sum (
        .bit_sym_i (bit_sym),
        .res_i     (res),
        .carry_o   (carry_c),
        .sum_o     (sum_c)
    );

    // Plain arithmetic reference, used only by the properties below
    assign ref_total = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, cin};

    // R3: a prefix that starts from a resolved carry-in never stays at propagate
    for (genvar j = 0; j < COUNT; j++) begin : g_res_chk
        p_resolved_r3: assert property (@(posedge clk) disable iff (rst)
            res[j] != SYM_PROP);
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                sum_out   <= '0;
                carry_out <= '0;
            end else begin
                sum_out   <= sum_c;
                carry_out <= carry_c;
            end
        end

        p_reset_clear_r8: assert property (@(posedge clk)
            rst |=> (sum_out == '0 && carry_out == '0));

        p_cin_entry_r4: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> carry_out[0] == $past(cin));

        p_sum_total_r7: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> {carry_out[WIDTH], sum_out} == $past(ref_total));

        for (genvar k = 0; k < WIDTH; k++) begin : g_link
            p_ripple_link_r5: assert property (@(posedge clk) disable iff (rst)
                1'b1 |=> carry_out[k+1] ==
                    ($past(a_in[k] & b_in[k]) |
                     ($past(a_in[k] ^ b_in[k]) & carry_out[k])));
        end
    end else begin : g_comb
        assign sum_out   = sum_c;
        assign carry_out = carry_c;

        p_cin_entry_r4: assert property (@(posedge clk) disable iff (rst)
            carry_out[0] == cin);

        p_sum_total_r6: assert property (@(posedge clk) disable iff (rst)
            {carry_out[WIDTH], sum_out} == ref_total);

        for (genvar k = 0; k < WIDTH; k++) begin : g_link
            p_ripple_link_r2: assert property (@(posedge clk) disable iff (rst)
                carry_out[k+1] ==
                    ((a_in[k] & b_in[k]) | ((a_in[k] ^ b_in[k]) & carry_out[k])));
        end
    end

endmodule

// File: tb/sim_pfx_carry_adder.sv
`timescale 1ns/1ps
module sim_pfx_carry_adder;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    // 32-bit registered instance
    logic [31:0] a0 = '0, b0 = '0, s0;
    logic        c0 = 1'b0;
    logic [32:0] k0;

    // 8-bit combinational instance
    logic [7:0] a1 = '0, b1 = '0, s1;
    logic       c1 = 1'b0;
    logic [8:0] k1;

    int n_chk = 0;
    int n_err = 0;
    logic [31:0] prev_s = '0;
    logic [32:0] prev_k = '0;

    pfx_carry_adder #(.WIDTH(32), .REG_OUT(1'b1)) u0 (
        .clk(clk), .rst(rst), .a_in(a0), .b_in(b0), .cin(c0),
        .sum_out(s0), .carry_out(k0)
    );

    pfx_carry_adder #(.WIDTH(8), .REG_OUT(1'b0)) u1 (
        .clk(clk), .rst(rst), .a_in(a1), .b_in(b1), .cin(c1),
        .sum_out(s1), .carry_out(k1)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [32:0] exp_car32(logic [31:0] a, logic [31:0] b, logic ci);
        logic [32:0] r;
        for (int k = 0; k <= 32; k++) begin
            logic [63:0] m;
            logic [63:0] t;
            m = (64'd1 << k) - 64'd1;
            t = ({32'd0, a} & m) + ({32'd0, b} & m) + {63'd0, ci};
            r[k] = t[k];
        end
        return r;
    endfunction

    function automatic logic [8:0] exp_car8(logic [7:0] a, logic [7:0] b, logic ci);
        logic [32:0] w;
        w = exp_car32({24'd0, a}, {24'd0, b}, ci);
        return w[8:0];
    endfunction

    // Drive u0 and check the one-cycle latency and the result (R5, R6, R7)
    task automatic run32(input logic [31:0] a, input logic [31:0] b, input logic ci, input string req);
        logic [63:0] tot;
        @(negedge clk);
        a0 = a; b0 = b; c0 = ci;
        #1;
        chk({req, " R7 hold"}, {31'd0, k0[32], s0}, {31'd0, prev_k[32], prev_s});
        @(negedge clk);
        tot = {32'd0, a} + {32'd0, b} + {63'd0, ci};
        chk({req, " R6 sum"}, {31'd0, k0[32], s0}, tot);
        chk({req, " R5 carries"}, {31'd0, k0}, {31'd0, exp_car32(a, b, ci)});
        prev_s = tot[31:0];
        prev_k = exp_car32(a, b, ci);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        a0 = 32'hFFFF_FFFF; b0 = 32'h1; c0 = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R8 reset sum", {32'd0, s0}, 64'd0);
        chk("R8 reset carries", {31'd0, k0}, 64'd0);
        a0 = '0; b0 = '0; c0 = 1'b0;
        rst = 1'b0;
        prev_s = '0;
        prev_k = '0;
    endtask

    task automatic t_prop_chain;
        run32(32'hFFFF_FFFF, 32'h0, 1'b1, "R2 chain cin1");
        chk("R2 all carries set", {31'd0, k0}, {31'd0, 33'h1_FFFF_FFFF});
        run32(32'hFFFF_FFFF, 32'h0, 1'b0, "R2 chain cin0");
        chk("R4 carry-out follows cin", {63'd0, k0[32]}, 64'd0);
        run32(32'h0, 32'h0, 1'b1, "R4 cin only");
        chk("R4 carry0 is cin", {31'd0, k0}, 64'd1);
    endtask

    task automatic t_absorb;
        run32(32'h0000_FFFF, 32'h0, 1'b1, "R3 annihilate at 16");
        chk("R3 carry above kill", {63'd0, k0[17]}, 64'd0);
        run32(32'hFFFF_FFFF, 32'h1, 1'b0, "R3 generate at 0");
        chk("R3 carry-out from generate", {63'd0, k0[32]}, 64'd1);
        run32(32'h8000_0000, 32'h8000_0000, 1'b0, "R3 generate at msb");
        run32(32'h7FFF_FFFF, 32'h7FFF_FFFF, 1'b1, "R3 mixed");
    endtask

    // Per-bit symbol behaviour with a propagate run below bit i (R1, R2, R3)
    task automatic t_encode8;
        for (int i = 0; i < 8; i++) begin
            for (int pat = 0; pat < 4; pat++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    logic [7:0] lowm;
                    logic       expc;
                    @(negedge clk);
                    lowm = 8'((16'd1 << i) - 16'd1);
                    a1 = lowm | (pat[1] ? 8'(1 << i) : 8'h0);
                    b1 = pat[0] ? 8'(1 << i) : 8'h0;
                    c1 = ci[0];
                    #1;
                    if (pat == 3)      expc = 1'b1;
                    else if (pat == 0) expc = 1'b0;
                    else               expc = ci[0];
                    chk("R1 symbol class carry", {63'd0, k1[i+1]}, {63'd0, expc});
                end
            end
        end
    endtask

    task automatic t_exhaustive8;
        for (int ci = 0; ci < 2; ci++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    logic [8:0] tot;
                    @(negedge clk);
                    a1 = 8'(a); b1 = 8'(b); c1 = ci[0];
                    #1;
                    tot = 9'(a) + 9'(b) + 9'(ci);
                    chk("R6 R7 exhaustive sum", {55'd0, k1[8], s1}, {55'd0, tot});
                    chk("R5 exhaustive carries", {55'd0, k1}, {55'd0, exp_car8(8'(a), 8'(b), ci[0])});
                end
            end
        end
    endtask

    task automatic t_random32;
        for (int n = 0; n < 2000; n++) begin
            run32($urandom, $urandom, n[0], "R5 random");
        end
    endtask

    initial begin
        #780000;
        n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        t_reset();
        t_prop_chain();
        t_absorb();
        t_encode8();
        t_exhaustive8();
        t_random32();
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule